// File: doc/BRIEF.md
# UART Address and Character Match Detector

This block sits beside a UART receiver and inspects every character the receiver finishes. It holds an 8-bit match code and compares each character against it in one of three ways. In run mode, all eight bits must match, and the character-match flag is then raised. This is useful, for example, to spot the end of a block. A character whose top bit is 1 is an address mark. An address mark is compared on its low four bits or on its low seven bits, and a hit can raise a wake flag. When mute operation is enabled, an address-mark hit releases the node from mute. A mark that misses puts the node back into mute.

Received characters arrive on a valid/ready stream. `rx_ready` is held high at all times, so the block never applies back-pressure. A character is consumed on every cycle in which `rx_valid` is high, the UART is enabled and reception is enabled. A character offered while the UART or reception is disabled is dropped with no effect. The two flags are sticky until software clears them. The interrupt line combines each flag with its own enable.

Top module: `uart_addr_match`

## Requirements
- R1: The match code loads from `cfg_addr` on `cfg_wr` only while `rx_en` or `uart_en` is 0. A write while both are 1 is ignored.
- R2: When the node is not muted, an accepted character equal to all 8 bits of the match code sets `match_flag` one cycle later.
- R3: With `addr7_mode` = 0, an address mark hits when `rx_data[3:0]` equals match code bits [3:0].
- R4: With `addr7_mode` = 1, an address mark hits when `rx_data[6:0]` equals match code bits [6:0].
- R5: A character is an address mark only when `rx_data[7]` = 1. A character with bit 7 = 0 never causes an address hit.
- R6: An address hit sets `wake_flag` only when `wake_sel` = 2'b00. Any other `wake_sel` value leaves `wake_flag` unchanged.
- R7: `match_flag` and `wake_flag` stay set until their clear pulse (`match_clr`, `wake_clr`). If a new set and a clear occur in the same cycle, the flag stays set.
- R8: `irq` = (`match_flag` AND `match_ie`) OR (`wake_flag` AND `wake_ie`).
- R9: With `mute_mode_en` = 1, a `mute_enter` pulse sets `muted`. An address-mark hit clears `muted` in the same cycle that it sets `wake_flag`. An address mark that misses sets `muted`. With `mute_mode_en` = 0, `muted` is 0.
- R10: Characters are evaluated only on cycles where `rx_valid`, `uart_en` and `rx_en` are all 1. `rx_ready` is always 1.
- R11: While `muted` is 1, no character sets `match_flag`.
- R12: After reset, both flags, `irq` and `muted` are 0, and the match code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | UART enable |
| rx_en | input | 1 | Receive enable |
| rx_valid | input | 1 | Received-character strobe |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Received character |
| cfg_wr | input | 1 | Match code write strobe |
| cfg_addr | input | 8 | Match code write data |
| addr7_mode | input | 1 | 1 selects 7-bit address compare, 0 selects 4-bit |
| mute_mode_en | input | 1 | Enables mute operation |
| mute_enter | input | 1 | Pulse that enters mute |
| wake_sel | input | 2 | Wake source select; 2'b00 is the address hit |
| wake_ie | input | 1 | Wake interrupt enable |
| match_ie | input | 1 | Match interrupt enable |
| match_clr | input | 1 | Clears match_flag |
| wake_clr | input | 1 | Clears wake_flag |
| match_flag | output | 1 | Sticky character-match flag |
| wake_flag | output | 1 | Sticky wake flag |
| irq | output | 1 | Interrupt request |
| muted | output | 1 | Mute state |

## Verification
The main function is driven with a table of code/character pairs:
- Pairs that match on all eight bits separate the full compare from the address compares.
- Pairs that match only on the low nibble or the low seven bits separate 4-bit from 7-bit mode.
- Pairs with bit 7 cleared but matching low bits show that the mark requirement is enforced.

Directed sequences then cover the following:
- the write lock on the match code;
- dropped strobes;
- a clear and a set in the same cycle;
- each interrupt enable;
- non-zero wake-source selects;
- the mute entry and exit sequence, including characters presented while muted.

// File: rtl/uam_pkg.sv
package uam_pkg;
  localparam int CHAR_W = 8;
  localparam int NIB_W  = 4;
  localparam int WIDE_W = 7;

  typedef enum logic [1:0] {
    WAKE_ON_ADDR = 2'b00,
    WAKE_SRC_1   = 2'b01,
    WAKE_SRC_2   = 2'b10,
    WAKE_SRC_3   = 2'b11
  } wake_src_e;

  localparam int FLAG_MATCH = 0;
  localparam int FLAG_WAKE  = 1;
  localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/uam_code_reg.sv
module uam_code_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                code_q <= '0;
    else if (wr && !locked)    code_q <= wdata;
  end
endmodule

// File: rtl/uam_compare.sv
module uam_compare #(
  parameter int W      = 8,
  parameter int NIB    = 4,
  parameter int WIDE   = 7
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] code,
  input  logic         wide_mode,
  output logic         full_hit,
  output logic         is_mark,
  output logic         addr_hit
);
  logic nib_eq;
  logic wide_eq;

  always_comb begin
    full_hit = (data == code);
    is_mark  = data[W-1];
    nib_eq   = (data[NIB-1:0]  == code[NIB-1:0]);
    wide_eq  = (data[WIDE-1:0] == code[WIDE-1:0]);
    addr_hit = is_mark && (wide_mode ? wide_eq : nib_eq);
  end
endmodule

// File: rtl/uam_mute_ctl.sv
module uam_mute_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic enter,
  input  logic char_ok,
  input  logic is_mark,
  input  logic addr_hit,
  output logic muted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  muted <= 1'b0;
    else if (!mode_en)           muted <= 1'b0;
    else if (char_ok && is_mark) muted <= !addr_hit;
    else if (enter)              muted <= 1'b1;
  end
endmodule

// File: rtl/uam_sticky_flag.sv
module uam_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/uart_addr_match.sv
module uart_addr_match
  import uam_pkg::*;
#(
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_en,
  input  logic              rx_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_addr,
  input  logic              addr7_mode,
  input  logic              mute_mode_en,
  input  logic              mute_enter,
  input  logic [1:0]        wake_sel,
  input  logic              wake_ie,
  input  logic              match_ie,
  input  logic              match_clr,
  input  logic              wake_clr,
  output logic              match_flag,
  output logic              wake_flag,
  output logic              irq,
  output logic              muted
);
  localparam int NIB  = (NIB_W  < DATA_W) ? NIB_W  : DATA_W - 1;
  localparam int WIDE = (WIDE_W < DATA_W) ? WIDE_W : DATA_W - 1;

  logic [DATA_W-1:0]    code_q;
  logic                 char_ok;
  logic                 full_hit, is_mark, addr_hit;
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_q, f_ie;
  wake_src_e            wsrc;

  assign rx_ready = 1'b1;
  assign char_ok  = rx_valid && uart_en && rx_en;
  assign wsrc     = wake_src_e'(wake_sel);

  uam_code_reg #(.W(DATA_W)) u_code (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .locked(uart_en && rx_en), .wdata(cfg_addr), .code_q(code_q)
  );

  uam_compare #(.W(DATA_W), .NIB(NIB), .WIDE(WIDE)) u_cmp (
    .data(rx_data), .code(code_q), .wide_mode(addr7_mode),
    .full_hit(full_hit), .is_mark(is_mark), .addr_hit(addr_hit)
  );

  uam_mute_ctl u_mute (
    .clk(clk), .rst_n(rst_n), .mode_en(mute_mode_en), .enter(mute_enter),
    .char_ok(char_ok), .is_mark(is_mark), .addr_hit(addr_hit), .muted(muted)
  );

  always_comb begin
    f_set[FLAG_MATCH] = char_ok && !muted && full_hit;
    f_set[FLAG_WAKE]  = char_ok && addr_hit && (wsrc == WAKE_ON_ADDR);
    f_clr[FLAG_MATCH] = match_clr;
    f_clr[FLAG_WAKE]  = wake_clr;
    f_ie[FLAG_MATCH]  = match_ie;
    f_ie[FLAG_WAKE]   = wake_ie;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    uam_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(f_set[g]), .clr(f_clr[g]), .q(f_q[g])
    );
  end

  assign match_flag = f_q[FLAG_MATCH];
  assign wake_flag  = f_q[FLAG_WAKE];
  assign irq        = |(f_q & f_ie);
endmodule

// File: rtl/uam_checker.sv
module uam_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       mute_mode_en,
  input logic [1:0] wake_sel,
  input logic       match_clr,
  input logic       wake_clr,
  input logic       match_flag,
  input logic       wake_flag,
  input logic       irq,
  input logic       muted
);
  // R10
  no_idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !$rose(match_flag));
  // R7
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !wake_clr) |=> wake_flag);
  // R11
  muted_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    muted |=> !$rose(match_flag));
  // R9
  mute_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(muted) && $past(mute_mode_en)) |-> $past(rx_valid && rx_data[7]));
  // R6
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(wake_sel) == 2'b00));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && !wake_flag) |-> !irq);
endmodule

bind uart_addr_match uam_checker u_chk (.*);

// File: tb/uart_addr_match_test.sv
`timescale 1ns/1ps
module uart_addr_match_test;
  logic clk = 0, rst_n = 0;
  logic uart_en = 1, rx_en = 1, rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0, cfg_addr = 0;
  logic cfg_wr = 0, addr7_mode = 0, mute_mode_en = 0, mute_enter = 0;
  logic [1:0] wake_sel = 0;
  logic wake_ie = 0, match_ie = 0, match_clr = 0, wake_clr = 0;
  logic match_flag, wake_flag, irq, muted;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_addr_match uut (.*);

  // {code[18:11], wide[10], data[9:2], exp_match[1], exp_wake[0]}
  localparam logic [18:0] VEC [10] = '{
    {8'hA5, 1'b0, 8'hA5, 1'b1, 1'b1},
    {8'hA5, 1'b0, 8'h25, 1'b0, 1'b0},
    {8'hA5, 1'b0, 8'hF5, 1'b0, 1'b1},
    {8'hA5, 1'b1, 8'hF5, 1'b0, 1'b0},
    {8'hA5, 1'b1, 8'hA5, 1'b1, 1'b1},
    {8'h25, 1'b1, 8'hA5, 1'b0, 1'b1},
    {8'h25, 1'b0, 8'h25, 1'b1, 1'b0},
    {8'h3C, 1'b0, 8'h8C, 1'b0, 1'b1},
    {8'h3C, 1'b0, 8'h8D, 1'b0, 1'b0},
    {8'hFF, 1'b0, 8'hFF, 1'b1, 1'b1}
  };

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_code(logic [7:0] a);
    @(negedge clk); rx_en = 0; cfg_wr = 1; cfg_addr = a;
    @(negedge clk); cfg_wr = 0; rx_en = 1;
  endtask

  task automatic send(logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); match_clr = 1; wake_clr = 1;
    @(negedge clk); match_clr = 0; wake_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 match_flag", match_flag, 0);
    chk("R12 wake_flag", wake_flag, 0);
    chk("R12 irq", irq, 0);
    chk("R12 muted", muted, 0);
    rst_n = 1;
    chk("R10 rx_ready", rx_ready, 1);
    // R12 code is 0x00 after reset
    send(8'h00);
    chk("R12 code zero", match_flag, 1);
    clear_flags();

    // R2 R3 R4 R5 table
    foreach (VEC[i]) begin
      set_code(VEC[i][18:11]);
      addr7_mode = VEC[i][10];
      send(VEC[i][9:2]);
      chk($sformatf("R2 vec%0d match", i), match_flag, VEC[i][1]);
      chk($sformatf("R3/R4/R5 vec%0d wake", i), wake_flag, VEC[i][0]);
      clear_flags();
    end
    addr7_mode = 0;

    // R1 write ignored while enabled (code is FF)
    @(negedge clk); cfg_wr = 1; cfg_addr = 8'h11;
    @(negedge clk); cfg_wr = 0;
    send(8'h11);
    chk("R1 locked write ignored", match_flag, 0);
    send(8'hFF);
    chk("R1 old code kept", match_flag, 1);
    clear_flags();
    @(negedge clk); uart_en = 0; cfg_wr = 1; cfg_addr = 8'h11;
    @(negedge clk); cfg_wr = 0; uart_en = 1;
    send(8'h11);
    chk("R1 write with uart off", match_flag, 1);
    clear_flags();

    // R10 dropped strobe
    @(negedge clk); rx_en = 0; rx_data = 8'h11; rx_valid = 1;
    @(negedge clk); rx_valid = 0; rx_en = 1;
    chk("R10 strobe with rx off", match_flag, 0);

    // R7 sticky and same-cycle priority
    send(8'h11);
    repeat (3) @(negedge clk);
    chk("R7 held", match_flag, 1);
    @(negedge clk); rx_data = 8'h11; rx_valid = 1; match_clr = 1;
    @(negedge clk); rx_valid = 0; match_clr = 0;
    chk("R7 set beats clear", match_flag, 1);
    @(negedge clk); match_clr = 1;
    @(negedge clk); match_clr = 0;
    chk("R7 cleared", match_flag, 0);

    // R8 interrupt enables
    send(8'h11);
    chk("R8 irq off with ie 0", irq, 0);
    match_ie = 1; #1;
    chk("R8 irq on match_ie", irq, 1);
    match_ie = 0; clear_flags();
    send(8'h91);
    chk("R8 wake flag set", wake_flag, 1);
    wake_ie = 1; #1;
    chk("R8 irq on wake_ie", irq, 1);
    wake_ie = 0; clear_flags();

    // R6 non-zero wake select
    wake_sel = 2'b01;
    send(8'h91);
    chk("R6 sel 01 no wake", wake_flag, 0);
    wake_sel = 2'b11;
    send(8'h91);
    chk("R6 sel 11 no wake", wake_flag, 0);
    wake_sel = 2'b00;

    // R9 R11 mute sequence
    set_code(8'h25);
    mute_mode_en = 1;
    @(negedge clk); mute_enter = 1;
    @(negedge clk); mute_enter = 0;
    chk("R9 enter mute", muted, 1);
    send(8'h25);
    chk("R11 no match while muted", match_flag, 0);
    chk("R9 non-mark stays muted", muted, 1);
    send(8'h85);
    chk("R9 hit leaves mute", muted, 0);
    chk("R9 wake with exit", wake_flag, 1);
    clear_flags();
    send(8'h86);
    chk("R9 miss re-enters mute", muted, 1);
    send(8'h25);
    chk("R11 muted again no match", match_flag, 0);
    mute_mode_en = 0;
    @(negedge clk);
    chk("R9 mode off clears mute", muted, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule